// File: doc/BRIEF.md
# Bidirectional Cascadable Sampling Pointer

This block is the digital column pointer of an analog source driver. A single active token walks across 80 stage positions, one position per rising clock edge, and each stage position enables the sample-and-hold circuits of one group of three output columns. A direction input sets the walk order: position 1 up to position 80, or position 80 down to 1.

The direction input also decides which of two bidirectional start/carry pins receives the start pulse and which one drives the carry pulse to the next driver in a cascade. The pin that is acting as an input has its output driver disabled. The carry pulse is raised one clock before this chip's own window closes, so the next chip can take over without a gap.

The run length is counted from the first captured start pulse. A fixed number of clocks after that pulse, the block clears its register and returns to standby. In standby the register is not clocked at all, which models the automatic clock stop. Start pulses that arrive during a run are shifted into the register as extra tokens, but they do not extend the run.

Top module: `col_pointer`

## Requirements
- R1: With `dir_fwd` high, `pin_l_i` is the start input, `pin_l_oe` is 0 and `pin_r_oe` is 1. With `dir_fwd` low, the roles swap: `pin_r_i` is the start input, `pin_l_oe` is 1 and `pin_r_oe` is 0.
- R2: In standby, a high level on the active start input at a rising edge starts a run. After that edge `busy` is 1 and exactly the first stage is active. The first stage is bit 0 of `stage_act` (position 1) when `dir_fwd` is high, and bit STAGES-1 (position 80) when `dir_fwd` is low.
- R3: Bit i of `stage_act` is stage position i+1. A token captured at a given edge is at the m-th stage in walk order after m further edges, and leaves the register after STAGES edges.
- R4: The carry pulse is high for exactly the one clock period that follows the STAGES-th edge after the capture edge. It appears on `pin_r_o` when `dir_fwd` is high and on `pin_l_o` when `dir_fwd` is low. Both carry outputs are 0 at all other times.
- R5: At the edge STAGES+1 edges after the capture edge, `busy` drops to 0 and `stage_act` clears to 0.
- R6: A start pulse seen while `busy` is 1 is shifted in as an additional token at the first stage. It does not move the standby edge given by R5.
- R7: In standby with no start pulse, nothing changes: `stage_act` stays 0, `busy` stays 0 and the carry pins stay low. A high level on the pin that is currently the output is ignored.
- R8: When `rst_n` is low at a rising edge, the register clears, the run counter clears and the block enters standby.
- R9: A start pulse present on the same edge where R5 ends a run begins a fresh run, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; everything changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_fwd | input | 1 | Walk direction and pin role select (1 = position 1 upward) |
| pin_l_i | input | 1 | Input level seen on the left start/carry pin |
| pin_r_i | input | 1 | Input level seen on the right start/carry pin |
| pin_l_o | output | 1 | Carry drive for the left pin |
| pin_l_oe | output | 1 | Output enable for the left pin |
| pin_r_o | output | 1 | Carry drive for the right pin |
| pin_r_oe | output | 1 | Output enable for the right pin |
| stage_act | output | STAGES | Active stage positions; bit i is position i+1 |
| busy | output | 1 | High from the capture edge until standby |

## Verification
The bench builds the block with its default of 80 stages. This is the real register length, so the carry edge, the standby edge and both end positions are checked at their true clock counts. Runs are cheap, so it exercises full walks in both directions, bursts of overlapping start pulses, a restart on the termination edge and a reset in the middle of a run. On top of these, it mixes in random pulses, random levels on the pin that is acting as the output, and random direction changes during standby.

// File: rtl/col_pointer.sv
module col_pointer #(
  parameter int STAGES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  input  logic              pin_l_i,
  input  logic              pin_r_i,
  output logic              pin_l_o,
  output logic              pin_l_oe,
  output logic              pin_r_o,
  output logic              pin_r_oe,
  output logic [STAGES-1:0] stage_act,
  output logic              busy
);
  localparam int CW = $clog2(STAGES + 1) + 1;
  localparam logic [CW-1:0] AGE_CARRY = CW'(STAGES - 1);
  localparam logic [CW-1:0] AGE_END   = CW'(STAGES);

  logic [STAGES-1:0] chain;
  logic [CW-1:0]     age;
  logic              run;
  logic              carry;

  wire start_in = dir_fwd ? pin_l_i : pin_r_i;
  wire at_end   = run && (age == AGE_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      age   <= '0;
      run   <= 1'b0;
      carry <= 1'b0;
    end else begin
      carry <= run && (age == AGE_CARRY);
      if (!run || at_end) begin
        if (start_in) begin
          chain <= {{(STAGES-1){1'b0}}, 1'b1};
          age   <= '0;
          run   <= 1'b1;
        end else if (at_end) begin
          chain <= '0;
          age   <= '0;
          run   <= 1'b0;
        end
      end else begin
        chain <= {chain[STAGES-2:0], start_in};
        age   <= age + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_map
    assign stage_act[i] = dir_fwd ? chain[i] : chain[STAGES-1-i];
  end

  assign busy     = run;
  assign pin_r_oe = dir_fwd;
  assign pin_l_oe = !dir_fwd;
  assign pin_r_o  = carry && dir_fwd;
  assign pin_l_o  = carry && !dir_fwd;

  // guards on the start, carry and standby sequencing
  p_pin_roles_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pin_l_oe != pin_r_oe);

  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_in) |=> (busy && stage_act != '0));

  p_carry_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_l_o || pin_r_o) |=> !(pin_l_o || pin_r_o));

  p_carry_then_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_l_o || pin_r_o) && !start_in) |=> (!busy && stage_act == '0));

  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> stage_act == '0);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_in) |=> (!busy && $stable(stage_act) && !pin_l_o && !pin_r_o));

  p_input_pin_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_l_o && pin_l_oe == 1'b0) && !(pin_r_o && pin_r_oe == 1'b0));

  p_age_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    age <= AGE_END);
endmodule

// File: tb/sim_col_pointer.sv
module sim_col_pointer;
  localparam int STAGES = 80;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n, dir_fwd, pin_l_i, pin_r_i;
  logic pin_l_o, pin_l_oe, pin_r_o, pin_r_oe, busy;
  logic [STAGES-1:0] stage_act;

  int tests = 0;
  int fails = 0;

  logic          m_busy;
  int            m_age;
  logic [STAGES:0] capmask;

  col_pointer #(.STAGES(STAGES)) u0 (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
    .pin_l_i(pin_l_i), .pin_r_i(pin_r_i),
    .pin_l_o(pin_l_o), .pin_l_oe(pin_l_oe),
    .pin_r_o(pin_r_o), .pin_r_oe(pin_r_oe),
    .stage_act(stage_act), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [STAGES-1:0] act, input logic [STAGES-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [STAGES-1:0] exp_act(input logic d);
    logic [STAGES-1:0] v = '0;
    if (m_busy)
      for (int c = 0; c <= m_age; c++)
        if (capmask[c] && (m_age - c) < STAGES)
          if (d) v[m_age - c] = 1'b1;
          else   v[STAGES-1-(m_age - c)] = 1'b1;
    return v;
  endfunction

  function automatic logic exp_carry();
    return m_busy && (m_age == STAGES);
  endfunction

  task automatic model_edge(input logic s, input logic rs);
    if (!rs) begin
      m_busy = 0; m_age = 0; capmask = '0;
    end else if (!m_busy || m_age == STAGES) begin
      if (s) begin
        m_busy = 1; m_age = 0; capmask = '0; capmask[0] = 1'b1;
      end else if (m_busy) begin
        m_busy = 0; m_age = 0; capmask = '0;
      end
    end else begin
      m_age++;
      if (s) capmask[m_age] = 1'b1;
    end
  endtask

  task automatic cyc(input logic d, input logic l, input logic r, input logic rs);
    @(negedge clk);
    dir_fwd = d; pin_l_i = l; pin_r_i = r; rst_n = rs;
    @(posedge clk);
    model_edge(d ? l : r, rs);
    #1;
    chk("R3 stage_act", stage_act, exp_act(d));
    chk("R5 busy", STAGES'(busy), STAGES'(m_busy));
    chk("R4 carry right", STAGES'(pin_r_o), STAGES'(d && exp_carry()));
    chk("R4 carry left", STAGES'(pin_l_o), STAGES'(!d && exp_carry()));
    chk("R1 output enables", STAGES'({pin_l_oe, pin_r_oe}), STAGES'(d ? 2'b01 : 2'b10));
  endtask

  task automatic pulse(input logic d);
    cyc(d, d, !d, 1'b1);
  endtask

  task automatic idle(input logic d, input int n);
    for (int i = 0; i < n; i++) cyc(d, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    m_busy = 0; m_age = 0; capmask = '0;
    rst_n = 0; dir_fwd = 1; pin_l_i = 0; pin_r_i = 0;
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    chk("R8 reset stage_act", stage_act, '0);
    chk("R8 reset busy", STAGES'(busy), '0);

    // R7: a high level on the output-role pin is ignored in standby
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 1);
    chk("R7 idle ignores output pin", STAGES'(busy), '0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1);
    chk("R7 idle ignores output pin dir low", stage_act, '0);

    // R2/R3/R4/R5 forward walk
    pulse(1);
    chk("R2 first stage forward", stage_act, STAGES'(1));
    idle(1, STAGES - 1);
    chk("R3 last stage forward", stage_act, {1'b1, {(STAGES-1){1'b0}}});
    idle(1, 1);
    chk("R4 carry on right pin", STAGES'(pin_r_o), STAGES'(1));
    idle(1, 1);
    chk("R5 standby after run", STAGES'(busy), '0);

    // reverse walk
    pulse(0);
    chk("R2 first stage reverse", stage_act, {1'b1, {(STAGES-1){1'b0}}});
    idle(0, STAGES);
    chk("R4 carry on left pin", STAGES'(pin_l_o), STAGES'(1));
    idle(0, 1);
    chk("R5 standby reverse", stage_act, '0);

    // R6 several pulses; standby still tied to the first
    pulse(1); pulse(1); pulse(1);
    idle(1, 37);
    pulse(1);
    idle(1, STAGES - 41);
    chk("R6 still busy before end", STAGES'(busy), STAGES'(1));
    idle(1, 1);
    idle(1, 1);
    chk("R6 standby despite extra tokens", STAGES'(busy), '0);

    // R9 start on the terminating edge
    pulse(1);
    idle(1, STAGES);
    pulse(1);
    chk("R9 restart on end edge", stage_act, STAGES'(1));
    idle(1, STAGES + 2);

    // R8 reset mid-run
    pulse(0);
    idle(0, 20);
    cyc(0, 0, 0, 0);
    chk("R8 mid-run reset clears", stage_act, '0);
    idle(0, 3);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic d, s, other, rs;
      d = dir_fwd;
      if (!m_busy && ($urandom % 50) == 0) d = ~d;
      s = (($urandom % 40) == 0);
      other = $urandom % 2;
      rs = (($urandom % 2000) != 0);
      cyc(d, d ? s : other, d ? other : s, rs);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule